// File: doc/BRIEF.md
# Time-Shared Unsigned Multiplier with Ready Handshake

This block is a single unsigned multiplier that several requesters use one after another. A typical case is the four output channels of a colour pipeline. Using one unit in place of one multiplier per channel saves area. The requester places two operands on the input ports and pulses `load` for one cycle. The block captures the operands on that edge and forms the product over two internal steps: a low-half partial product first, then the high-half partial product added to it. It then raises `ready`.

`ready` stays high for exactly two cycles. This gives the requester one spare cycle to sample the result. After the window the product stays on the output until the next accepted request overwrites it. A load that arrives while the unit is working, or while `ready` is high, is dropped. A requester that waits for `ready` before it issues the next load can therefore chain requests every five cycles.

Top module: `seqmul_share`

## Requirements
- R1: After a synchronous active-low reset, `ready` is 0 and `product` is 0.
- R2: The result is the full 16-bit unsigned product `mult_a * mult_b` of the operands present on the accepting clock edge.
- R3: When `load` is sampled high at edge k while the unit is idle, `ready` first reads 1 after edge k+2. `product` takes the new value on that same edge.
- R4: `ready` is high for exactly two consecutive cycles (after edges k+2 and k+3) and is low again after edge k+4.
- R5: `product` keeps its value from edge k+2 until the edge at which a later accepted request writes its result.
- R6: A `load` sampled on edges k+1 through k+4 is ignored. It does not restart the sequence or stretch `ready`, and the operands on the port at that time never affect `product`.
- R7: A new load sampled at edge k+5 is accepted, so four requests in a row each return their own correct product.
- R8: A reset applied in the middle of an operation clears `ready` and `product` at once. No stale `ready` follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Request strobe, sampled on the rising edge |
| mult_a | input | 8 | First unsigned operand |
| mult_b | input | 8 | Second unsigned operand |
| ready | output | 1 | High for two cycles when the result is valid |
| product | output | 16 | Unsigned product register |

## Verification
The embedded properties assume that the operand ports carry known values on any edge where `load` is high. They also assume that reset is held for at least one edge before any request, so that the three-cycle history used for the product check starts from a cleared state. The stimulus drives operands and `load` only on falling edges and always gives defined values. Between requests it deliberately puts scrambled operands on the ports, including during the busy window, to show that only the accepting edge matters.

// File: rtl/seqmul_pkg.sv
// Shared definitions for the time-shared multiplier.
// Assumes: nothing beyond standard SystemVerilog.
package seqmul_pkg;
    // Sequencer states: idle, low partial, high partial, two ready cycles.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LO   = 3'd1,
        ST_HI   = 3'd2,
        ST_RDY1 = 3'd3,
        ST_RDY2 = 3'd4
    } mstate_t;
endpackage

// File: rtl/seqmul_ctrl.sv
// Sequencer for the shared multiplier: accepts a request only when idle,
// steps through two compute states, then holds ready for two cycles.
// Assumes: load is a level sampled on every rising edge; reset is synchronous.
module seqmul_ctrl
    import seqmul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic accept,
    output logic do_lo,
    output logic do_hi,
    output logic ready
);
    mstate_t state_q, state_d;

    // Next-state selection; requests outside idle are dropped.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load) state_d = ST_LO;
            ST_LO:   state_d = ST_HI;
            ST_HI:   state_d = ST_RDY1;
            ST_RDY1: state_d = ST_RDY2;
            ST_RDY2: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Decoded strobes for the datapath and the handshake output.
    always_comb begin
        accept = (state_q == ST_IDLE) && load;
        do_lo  = (state_q == ST_LO);
        do_hi  = (state_q == ST_HI);
        ready  = (state_q == ST_RDY1) || (state_q == ST_RDY2);
    end

    // R3: ready appears after the second edge following acceptance.
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready ##1 !ready ##1 ready);

    // R4: ready is never a single-cycle pulse.
    p_ready_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |=> ready);

    // R4: ready never lasts beyond two cycles.
    p_ready_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |=> !ready);

    // R6: a busy unit never starts a new low-partial step.
    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready || do_lo || do_hi) |=> !do_lo);
endmodule

// File: rtl/seqmul_dp.sv
// Datapath for the shared multiplier: operand capture, low-half partial
// product, then high-half partial added and written to the result register.
// Assumes: DW is even; strobes come one per cycle from the sequencer.
module seqmul_dp #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            do_lo,
    input  logic            do_hi,
    input  logic [DW-1:0]   a_in,
    input  logic [DW-1:0]   b_in,
    output logic [2*DW-1:0] product
);
    localparam int PW = 2 * DW;
    localparam int HW = DW / 2;

    logic [DW-1:0] op_a_q, op_b_q;
    logic [PW-1:0] acc_q;
    logic [PW-1:0] part_lo, part_hi;

    // Partial products over the two halves of the second operand.
    always_comb begin
        part_lo = PW'(op_a_q) * PW'(op_b_q[HW-1:0]);
        part_hi = (PW'(op_a_q) * PW'(op_b_q[DW-1:HW])) << HW;
    end

    // Operand capture, only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_a_q <= '0;
            op_b_q <= '0;
        end else if (accept) begin
            op_a_q <= a_in;
            op_b_q <= b_in;
        end
    end

    // Low-half accumulation step.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (do_lo) acc_q <= part_lo;
    end

    // Result register: written once per request, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     product <= '0;
        else if (do_hi) product <= acc_q + part_hi;
    end

    // R5: result changes only on the final compute step.
    p_product_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !do_hi |=> $stable(product));
endmodule

// File: rtl/seqmul_share.sv
// Top of the time-shared multiplier: one unsigned DW x DW unit with a
// load/ready handshake; ready lasts two cycles, busy loads are dropped.
// Assumes: requesters wait for ready before issuing the next load.
module seqmul_share #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DW-1:0]   mult_a,
    input  logic [DW-1:0]   mult_b,
    output logic            ready,
    output logic [2*DW-1:0] product
);
    localparam int PW = 2 * DW;

    logic accept, do_lo, do_hi;

    seqmul_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .accept (accept),
        .do_lo  (do_lo),
        .do_hi  (do_hi),
        .ready  (ready)
    );

    seqmul_dp #(.DW(DW)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .do_lo   (do_lo),
        .do_hi   (do_hi),
        .a_in    (mult_a),
        .b_in    (mult_b),
        .product (product)
    );

    // R2: on the rising edge of ready the product matches the port
    // operands seen three edges earlier, when load was sampled.
    p_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(load, 3) &&
            product == PW'($past(mult_a, 3)) * PW'($past(mult_b, 3))));
endmodule

// File: tb/seqmul_share_tb_top.sv
`timescale 1ns/1ps
module seqmul_share_tb_top;
    localparam int DW = 8;
    localparam int NV = 10;
    localparam logic [2*DW-1:0] VEC [NV] = '{
        16'h0000, 16'hFFFF, 16'h01FF, 16'hFF01, 16'h0F0F,
        16'hF00F, 16'h8080, 16'h0D07, 16'h00A5, 16'hC3E1
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load = 1'b0;
    logic [DW-1:0]   mult_a = '0;
    logic [DW-1:0]   mult_b = '0;
    logic            ready;
    logic [2*DW-1:0] product;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    seqmul_share #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .load(load),
        .mult_a(mult_a), .mult_b(mult_b),
        .ready(ready), .product(product)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One request from a falling edge; returns at the falling edge after k+4.
    task automatic run(input logic [DW-1:0] a, input logic [DW-1:0] b, input bit busy_load);
        logic [2*DW-1:0] exp;
        exp = (2*DW)'(a) * (2*DW)'(b);
        load = 1'b1; mult_a = a; mult_b = b;
        @(posedge clk); @(negedge clk);           // after edge k
        load = busy_load; mult_a = ~a; mult_b = b ^ 8'h5A;
        chk("R3 ready low after k", 32'(ready), 0);
        @(negedge clk);                           // after k+1
        chk("R3 ready low after k+1", 32'(ready), 0);
        @(negedge clk);                           // after k+2
        chk("R3 ready high after k+2", 32'(ready), 1);
        chk("R2 product value", 32'(product), 32'(exp));
        @(negedge clk);                           // after k+3
        chk("R4 ready second cycle", 32'(ready), 1);
        @(negedge clk);                           // after k+4
        load = 1'b0;
        chk("R4 ready low after window", 32'(ready), 0);
        chk("R5 product held", 32'(product), 32'(exp));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset ready", 32'(ready), 0);
        chk("R1 reset product", 32'(product), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walked back to back (R2, R7).
        for (int i = 0; i < NV; i++)
            run(VEC[i][15:8], VEC[i][7:0], 1'b0);

        // R6: load held high through the busy window is ignored.
        run(8'd3, 8'd5, 1'b1);
        @(negedge clk);
        chk("R6 no restart ready", 32'(ready), 0);
        @(negedge clk); @(negedge clk);
        chk("R6 no late ready", 32'(ready), 0);
        chk("R6 product unaffected", 32'(product), 15);

        // R7: four channel requests back to back.
        run(8'd200, 8'd17, 1'b0);
        run(8'd64, 8'd255, 1'b0);
        run(8'd1, 8'd1, 1'b0);
        run(8'd255, 8'd128, 1'b0);

        // R8: reset in the middle of an operation.
        load = 1'b1; mult_a = 8'd9; mult_b = 8'd9;
        @(posedge clk); @(negedge clk);
        load = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 ready cleared", 32'(ready), 0);
        chk("R8 product cleared", 32'(product), 0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R8 no stale ready", 32'(ready), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule